// File: doc/BRIEF.md
# Subframe Sync Tracker for a 12-bit Flight Data Stream

This block sits behind a line decoder that already turns the differential line into one data bit per strobe. It hunts for the four subframe sync marks and then counts bits into 12-bit words aligned to those marks. It keeps count of word and subframe position and raises `in_sync` according to one of three acquisition policies. Framed words leave on a valid/ready write port, each tagged with its subframe index, toward a receive FIFO that sits outside the block.

The subframe length in words follows the selected rate, `64 << rate_sel`, and each subframe lasts one second. While tracking, the sync word is compared only at the word-0 slot, so sync patterns inside user data are ignored. A missing mark drops sync and pulses a discard flag for the subframe just received. A match output marks one programmed word position within one programmed subframe.

The bit stream cannot be stalled. The write port therefore holds one word. `wr_valid` stays high with stable data until `wr_ready` is seen high at a clock edge. If a new word completes while the held word is still unaccepted, the new word replaces it. `mode` is expected to be static between resets. `rate_sel` is read continuously.

Top module: `a717_sync_tracker`

## Requirements
- R1: Bits are shifted in on `bit_valid`. The first bit of a word is its MSB. In tracking modes every written word is the 12 bits that follow a sync-aligned word boundary.
- R2: In flight-recorder mode (`mode`=0), only 0x247 starts acquisition. The marks 0x5B8, 0xA47 and 0xDB8 must then appear as word 0 of each following subframe, each subframe being `64 << rate_sel` words long. `in_sync` rises on the clock that takes the last bit of the next 0x247.
- R3: In test mode (`mode`=1), any of the four marks starts acquisition. `in_sync` rises on the clock that takes the last bit of the third mark, provided the marks arrive in cyclic order 0x247, 0x5B8, 0xA47, 0xDB8 at exact subframe spacing.
- R4: While in sync, a word 0 that differs from the expected mark clears `in_sync` on the clock that takes its last bit. `sub_discard` then pulses for exactly one cycle. In flight-recorder mode, re-acquisition starts only from 0x247.
- R5: Sync patterns inside data words of a tracked subframe do not affect `in_sync`.
- R6: Outside no-sync mode, no word is written while `in_sync` is low. The first word written is the one that completes 12 bits after `in_sync` rises, and a word 0 that breaks sync is not written.
- R7: In no-sync mode (`mode`=2 or 3), `in_sync` is high from the first clock after reset. Every group of 12 bits counted from reset is written without alignment, and `wr_sub` is 0.
- R8: `match` is high when `in_sync` is high, the mode is not no-sync, and both of these hold: the index of the word being received (0 = sync word) equals `match_word`, and the subframe index equals `match_sub`.
- R9: `match` is low whenever `rate_sel` is 7 (8192 words per subframe).
- R10: `wr_valid` with `wr_data`/`wr_sub` holds until `wr_ready` is seen at a clock edge. A word completing meanwhile replaces the held one.
- R11: A low `rst_n` sampled at a clock edge returns the block to searching, with `in_sync`, `match`, `wr_valid`, `sub_discard` and all counters cleared.
- R12: `wr_sub` gives the subframe index, 0 to 3, for marks 0x247, 0x5B8, 0xA47 and 0xDB8 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 flight recorder, 1 test, 2/3 no-sync |
| rate_sel | input | 3 | Subframe length is 64 << rate_sel words |
| bit_valid | input | 1 | Strobe for one decoded bit |
| bit_in | input | 1 | Decoded data bit |
| match_word | input | 13 | Programmed word index for the match output |
| match_sub | input | 2 | Programmed subframe index for the match output |
| in_sync | output | 1 | Sync flag |
| match | output | 1 | Position match flag |
| sub_discard | output | 1 | One-cycle pulse: the last subframe should be discarded |
| wr_valid | output | 1 | Write port holds a word |
| wr_ready | input | 1 | Consumer takes the held word at this edge |
| wr_data | output | 12 | Framed word |
| wr_sub | output | 2 | Subframe index of the framed word |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is loss of sync and completion of a word. The bench corrupts the word 0 of a later subframe. It then checks three things: that word never appears on the write port, `in_sync` falls at exactly that bit count, and one discard pulse appears. The second pair is a newly framed word and a held word still waiting for the consumer. In no-sync mode, `wr_ready` is kept low across several word completions. The bench checks that the held data stays stable between completions, that it is replaced by each newer word, and that the first word accepted after release is the latest one.

// File: rtl/a717_pkg.sv
package a717_pkg;
  localparam int WORD_W = 12;

  typedef enum logic [1:0] {
    MODE_FLIGHT = 2'd0,
    MODE_TEST   = 2'd1,
    MODE_RAW    = 2'd2
  } acq_mode_e;

  function automatic logic [WORD_W-1:0] sync_mark(input logic [1:0] idx);
    case (idx)
      2'd0:    sync_mark = 12'h247;
      2'd1:    sync_mark = 12'h5B8;
      2'd2:    sync_mark = 12'hA47;
      default: sync_mark = 12'hDB8;
    endcase
  endfunction
endpackage

// File: rtl/a717_framer.sv
module a717_framer
  import a717_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              hunt,
  output logic [WORD_W-1:0] cand,
  output logic              word_done
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [BW-1:0]     bitc_q;

  // newest bit at the LSB, so the first bit of a word lands at the MSB
  assign cand      = {sh_q[WORD_W-2:0], bit_in};
  assign word_done = bit_valid && (hunt || bitc_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bitc_q <= '0;
    end else if (bit_valid) begin
      sh_q   <= cand;
      bitc_q <= (hunt || bitc_q == LAST_BIT) ? '0 : bitc_q + BW'(1);
    end
  end

  p_phase_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hunt |=> (bitc_q == '0));
endmodule

// File: rtl/a717_sync_fsm.sv
module a717_sync_fsm
  import a717_pkg::*;
#(
  parameter int CW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [CW-1:0]     last_w,
  input  logic              word_done,
  input  logic [WORD_W-1:0] cand,
  output logic              hunt,
  output logic              lock,
  output logic              drop,
  output logic [CW-1:0]     wcnt,
  output logic [1:0]        sub,
  output logic              push,
  output logic [1:0]        push_sub
);
  logic       raw, trk_q, lock_q, drop_q;
  logic [1:0] sub_q, conf_q, hit_idx;
  logic [CW-1:0] wcnt_q;
  logic       hit_any, mark_ok;

  assign raw     = mode[1];
  assign hunt    = !raw && !trk_q;
  assign mark_ok = (cand == sync_mark(sub_q));

  always_comb begin
    hit_any = 1'b0;
    hit_idx = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (cand == sync_mark(2'(i))) begin
        hit_any = 1'b1;
        hit_idx = 2'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q  <= 1'b0;
      lock_q <= 1'b0;
      drop_q <= 1'b0;
      wcnt_q <= '0;
      sub_q  <= '0;
      conf_q <= '0;
    end else begin
      drop_q <= 1'b0;
      if (raw) begin
        lock_q <= 1'b1;
        trk_q  <= 1'b0;
      end else if (word_done) begin
        if (!trk_q) begin
          if ((mode == MODE_FLIGHT && cand == sync_mark(2'd0)) ||
              (mode == MODE_TEST && hit_any)) begin
            trk_q  <= 1'b1;
            sub_q  <= (mode == MODE_TEST) ? hit_idx : 2'd0;
            wcnt_q <= CW'(1);
            conf_q <= 2'd1;
          end
        end else if (wcnt_q == '0) begin
          if (mark_ok) begin
            wcnt_q <= CW'(1);
            if (!lock_q) begin
              if (mode == MODE_FLIGHT) begin
                if (sub_q == 2'd0) lock_q <= 1'b1;
              end else begin
                conf_q <= conf_q + 2'd1;
                if (conf_q == 2'd2) lock_q <= 1'b1;
              end
            end
          end else begin
            trk_q  <= 1'b0;
            lock_q <= 1'b0;
            drop_q <= lock_q;
            conf_q <= '0;
            wcnt_q <= '0;
          end
        end else if (wcnt_q >= last_w) begin
          wcnt_q <= '0;
          sub_q  <= sub_q + 2'd1;
        end else begin
          wcnt_q <= wcnt_q + CW'(1);
        end
      end
    end
  end

  assign push     = word_done && (raw || (lock_q && trk_q && (wcnt_q != '0 || mark_ok)));
  assign push_sub = raw ? 2'd0 : sub_q;
  assign lock     = lock_q;
  assign drop     = drop_q;
  assign wcnt     = wcnt_q;
  assign sub      = sub_q;

  p_fall_on_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(word_done));
  p_discard_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> (!lock_q && $past(lock_q)));
  p_rise_on_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_q) && !raw) |-> ($past(word_done) && $past(wcnt_q) == '0));
  p_sub_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q && $past(trk_q) && sub_q != $past(sub_q)) |-> (sub_q == $past(sub_q) + 2'd1));
endmodule

// File: rtl/a717_wr_stage.sv
module a717_wr_stage
  import a717_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic [1:0]        push_sub,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic [1:0]        wr_sub
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_sub   <= '0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_data  <= push_data;
      wr_sub   <= push_sub;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !push) |=> (wr_valid && $stable(wr_data) && $stable(wr_sub)));
endmodule

// File: rtl/a717_sync_tracker.sv
module a717_sync_tracker
  import a717_pkg::*;
#(
  parameter int BASE_WORDS = 64,
  parameter int RATE_W     = 3,
  localparam int NRATES    = 1 << RATE_W,
  localparam int CW        = $clog2(BASE_WORDS) + NRATES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic [CW-1:0]     match_word,
  input  logic [1:0]        match_sub,
  output logic              in_sync,
  output logic              match,
  output logic              sub_discard,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  output logic [1:0]        wr_sub
);
  logic [CW-1:0]     last_w, wcnt;
  logic [WORD_W-1:0] cand;
  logic              word_done, hunt, lock, push;
  logic [1:0]        sub, push_sub;

  assign last_w = CW'((BASE_WORDS << rate_sel) - 1);

  a717_framer u_framer (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .hunt(hunt), .cand(cand), .word_done(word_done)
  );

  a717_sync_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(mode), .last_w(last_w),
    .word_done(word_done), .cand(cand), .hunt(hunt), .lock(lock),
    .drop(sub_discard), .wcnt(wcnt), .sub(sub), .push(push), .push_sub(push_sub)
  );

  a717_wr_stage u_wr (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(cand), .push_sub(push_sub),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data), .wr_sub(wr_sub)
  );

  assign in_sync = lock;
  assign match   = lock && !mode[1] && (rate_sel != RATE_W'(NRATES - 1)) &&
                   (wcnt == match_word) && (sub == match_sub);

  p_no_write_unsynced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !in_sync && !$past(in_sync)) |-> !wr_valid);
endmodule

// File: tb/tb_a717_sync_tracker.sv
module tb_a717_sync_tracker;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  mode = 0;
  logic [2:0]  rate_sel = 0;
  logic        bit_valid = 0, bit_in = 0, wr_ready = 0;
  logic [12:0] match_word = 0;
  logic [1:0]  match_sub = 0;
  logic        in_sync, match, sub_discard, wr_valid;
  logic [11:0] wr_data;
  logic [1:0]  wr_sub;

  a717_sync_tracker dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_sel(rate_sel), .bit_valid(bit_valid),
    .bit_in(bit_in), .match_word(match_word), .match_sub(match_sub), .in_sync(in_sync),
    .match(match), .sub_discard(sub_discard), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_sub(wr_sub)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit bq[$];
  logic [13:0] exq[$], rcq[$];
  int sent, P, L, f0, lock_at, loss_at, r9_at, scen;
  int e_sync, e_match, first_bad, n_drop, drop_at;
  bit r9_done;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(int i);
    case (i % 4)
      0: return 12'h247;
      1: return 12'h5B8;
      2: return 12'hA47;
      default: return 12'hDB8;
    endcase
  endfunction

  function automatic logic [11:0] getw(int k);
    logic [11:0] w;
    for (int b = 0; b < 12; b++) w[11-b] = bq[12*k+b];
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bit_valid = 0; wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic build(int nfr, int words, int lockf, int badf);
    logic [11:0] w;
    bq.delete(); exq.delete(); rcq.delete();
    for (int i = 0; i < P; i++) bq.push_back(1'b0);
    for (int fi = 0; fi < nfr; fi++) begin
      int sb = (f0 + fi) % 4;
      for (int k = 0; k < words; k++) begin
        if (k == 0) w = (fi == badf) ? 12'h000 : mk(sb);
        else if (k == 7) w = 12'h247;   // false sync in user data (R5)
        else if (k == 9) w = 12'hDB8;
        else w = 12'($urandom);
        for (int b = 11; b >= 0; b--) bq.push_back(w[b]);
        if (fi < badf && (fi > lockf || (fi == lockf && k > 0)))
          exq.push_back({2'(sb), w});
      end
    end
  endtask

  task automatic observe();
    bit es, em;
    int rel, fr, wi, sb;
    if (wr_valid && wr_ready) rcq.push_back({wr_sub, wr_data});
    es = mode[1] ? 1'b1 : (sent >= lock_at && sent < loss_at);
    if (in_sync !== es) begin
      if (e_sync == 0) first_bad = sent;
      e_sync++;
    end
    em = 0;
    if (!mode[1] && es && rate_sel != 3'd7) begin
      rel = sent - P; fr = rel / L; wi = (rel % L) / 12; sb = (f0 + fr) % 4;
      em = (wi == int'(match_word)) && (sb == int'(match_sub));
    end
    if (match !== em) e_match++;
    if (sub_discard) begin n_drop++; drop_at = sent; end
    if (r9_at > 0 && sent == r9_at && !r9_done) begin
      r9_done = 1;
      chk(match === 1'b1, "R8", "match inside programmed slot", match, 1);
      rate_sel = 3'd7; #1;
      chk(match === 1'b0, "R9", "match with 8192-word rate", match, 0);
      rate_sel = 3'd0; #1;
    end
    if (scen == 3) begin
      if (sent == 12) chk(wr_valid && wr_data == getw(0), "R10", "first word offered", wr_data, getw(0));
      if (sent == 20) chk(wr_valid && wr_data == getw(0), "R10", "held word stable", wr_data, getw(0));
      if (sent == 24) chk(wr_valid && wr_data == getw(1), "R10", "held word replaced", wr_data, getw(1));
    end
  endtask

  task automatic run(bit gaps, int rdy_from);
    int idx = 0;
    sent = 0; e_sync = 0; e_match = 0; n_drop = 0; drop_at = -1; first_bad = -1; r9_done = 0;
    while (idx < bq.size()) begin
      @(negedge clk);
      wr_ready = (sent >= rdy_from);
      observe();
      if (!gaps || ($urandom % 4) != 0) begin
        bit_valid = 1; bit_in = bq[idx]; idx++; sent++;
      end else bit_valid = 0;
    end
    repeat (20) begin
      @(negedge clk); wr_ready = 1; observe(); bit_valid = 0;
    end
  endtask

  task automatic cmp_writes(string req);
    int bad = 0, n;
    chk(rcq.size() == exq.size(), "R6", "number of written words", rcq.size(), exq.size());
    n = (rcq.size() < exq.size()) ? rcq.size() : exq.size();
    for (int i = 0; i < n; i++) begin
      if (rcq[i] !== exq[i]) begin
        if (bad == 0) $display("FAIL %s word %0d: actual %h expected %h", req, i, rcq[i], exq[i]);
        bad++;
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd717));
    // reset state (R11)
    mode = 0; rate_sel = 0;
    do_reset();
    @(negedge clk);
    chk(in_sync === 0, "R11", "in_sync after reset", in_sync, 0);
    chk(wr_valid === 0, "R11", "wr_valid after reset", wr_valid, 0);
    chk(match === 0, "R11", "match after reset", match, 0);
    chk(sub_discard === 0, "R11", "sub_discard after reset", sub_discard, 0);

    // flight recorder: lock, false sync, match, loss (R1 R2 R4 R5 R6 R8 R9 R12)
    scen = 1; mode = 0; rate_sel = 0; L = 768; f0 = 0; P = 12 + int'($urandom % 9);
    match_word = 13'd5; match_sub = 2'd1;
    lock_at = P + 4*L + 12; loss_at = P + 8*L + 12; r9_at = P + 5*L + 5*12 + 6;
    build(10, 64, 4, 8);
    do_reset();
    run(1, 0);
    chk(e_sync == 0, "R2", "in_sync timeline incl. R5 false marks", first_bad, -1);
    chk(e_match == 0, "R8", "match timeline mismatches", e_match, 0);
    chk(r9_done, "R9", "rate probe reached", r9_done, 1);
    chk(n_drop == 1 && drop_at == loss_at, "R4", "discard pulse at bit count", drop_at, loss_at);
    cmp_writes("R1/R12 flight");

    // test mode starting from third mark (R3 R6 R8 R12)
    scen = 2; mode = 1; rate_sel = 1; L = 1536; f0 = 2; P = 30;
    match_word = 13'd3; match_sub = 2'd0;
    lock_at = P + 2*L + 12; loss_at = 32'h7fffffff; r9_at = 0;
    build(4, 128, 2, 99);
    do_reset();
    @(negedge clk);
    chk(in_sync === 0, "R11", "in_sync after second reset", in_sync, 0);
    run(1, 0);
    chk(e_sync == 0, "R3", "in_sync timeline in test mode", first_bad, -1);
    chk(e_match == 0, "R8", "match timeline in test mode", e_match, 0);
    chk(n_drop == 0, "R4", "no discard without loss", n_drop, 0);
    cmp_writes("R12 test");

    // no-sync mode with back-pressure (R7 R10)
    scen = 3; mode = 2; rate_sel = 0; L = 768; f0 = 0; P = 0;
    match_word = 13'd0; match_sub = 2'd0; lock_at = 0; loss_at = 0; r9_at = 0;
    bq.delete(); exq.delete(); rcq.delete();
    for (int i = 0; i < 144; i++) bq.push_back(1'($urandom));
    for (int k = 2; k < 12; k++) exq.push_back({2'b00, getw(k)});
    do_reset();
    run(0, 36);
    chk(e_sync == 0, "R7", "in_sync forced high", first_bad, -1);
    chk(e_match == 0, "R8", "match stays low in no-sync", e_match, 0);
    cmp_writes("R7/R10 raw");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule